// File: doc/BRIEF.md
# Dual-Slope Symmetric PWM Timer

This block is an 8-bit timer/counter that produces a symmetric, centre-aligned PWM waveform. The count rises from zero to a ceiling and falls back to zero, over and over. It advances only on cycles where the count-enable tick is high. The ceiling is either the full-scale value 0xFF or the active value of the period register. An output unit compares the count against the active duty register. It moves the PWM pin in one direction when a match happens on the rising slope and in the other direction when a match happens on the falling slope. A two-bit mode code selects which way round this works, or leaves the pin alone.

Both the period register and the duty register are double-buffered. A host write lands in a holding copy, and the holding copy is moved into the active copy only at the tick on which the count sits at the ceiling. Because of this, a period never mixes old and new settings. Two sticky flags report that the bottom was reached and that a compare match happened. The host clears each flag with its own strobe.

None of the inputs or outputs carries a data stream, so there is no valid/ready handshake. Every pin is a plain level or a single-cycle strobe, and the host can write a register in any cycle.

Top module: `dspwm_timer`

## Requirements
- R1: On ticks, the count runs 0,1,…,T,T−1,…,1,0,1,… where T is the current ceiling. T and 0 each last one tick, so a period is 2·T ticks. `count_up` is 1 on the rising slope and 0 on the falling slope, and it flips to 1 on the tick that leaves 0 while falling. With T = 0 the count stays at 0.
- R2: The count and the slope do not change on a cycle where `tick` is 0.
- R3: With `top_sel` = 0 the ceiling is 0xFF. With `top_sel` = 1 the ceiling is the active period register.
- R4: With `out_mode` = 2, a tick at count == active duty on the rising slope drives the pin to 0, and on the falling slope drives it to 1. A match at the ceiling counts as falling and a match at 0 counts as rising.
- R5: With `out_mode` = 3, the actions of R4 are inverted: 1 on a rising-slope match and 0 on a falling-slope match, with the same treatment of the ceiling and 0.
- R6: With `out_mode` = 0 or 1 the pin holds its last value.
- R7: A write to either register takes effect only at the next tick taken while the count equals the ceiling. A write in that same cycle waits for the following ceiling.
- R8: `bot_flag` becomes 1 after any tick whose next count is 0.
- R9: `cmp_flag` becomes 1 after any tick taken with count == active duty. This happens in every output mode.
- R10: Both flags are sticky and are cleared by their clear strobe. If a set and a clear happen in the same cycle, the set wins.
- R11: Synchronous reset gives count 0, rising slope, pin 0, both flags 0, period register 0xFF and duty register 0x80, in both the holding and the active copies.
- R12: In mode 2 with a constant duty of 0, the pin stays 0. With duty equal to the ceiling, the pin stays 1 from the first ceiling after the load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| tick | input | 1 | Count enable; the timer advances only when this is high |
| top_sel | input | 1 | 0: ceiling 0xFF; 1: ceiling from period register |
| out_mode | input | 2 | 0/1 hold, 2 clear-on-rise, 3 set-on-rise |
| per_wr | input | 1 | Write strobe for the period register |
| per_data | input | 8 | Period register write data |
| duty_wr | input | 1 | Write strobe for the duty register |
| duty_data | input | 8 | Duty register write data |
| bot_clr | input | 1 | Clear strobe for bottom flag |
| cmp_clr | input | 1 | Clear strobe for compare flag |
| pwm_out | output | 1 | PWM pin |
| count | output | 8 | Current count |
| count_up | output | 1 | 1 on rising slope |
| bot_flag | output | 1 | Sticky bottom-reached flag |
| cmp_flag | output | 1 | Sticky compare-match flag |

## Verification
The assertions check on every cycle that:
- the count moves by exactly one step per tick and freezes when there is no tick;
- the slope turns upward after leaving zero;
- the pin holds in modes 0 and 1;
- the bottom flag rises after the step from 1 down to 0;
- both flags stay set until they are cleared.

Only the bench's scenarios show the rest: the buffered register timing against the ceiling, the exact pin levels under both polarities including the matches at the ceiling and at zero, the constant-level duty corners, and the same-cycle set-versus-clear outcome. The bench uses a cycle model built from the requirements for these.

// File: rtl/dspwm_pkg.sv
package dspwm_pkg;

  typedef enum logic [1:0] {
    OM_HOLD0    = 2'd0,
    OM_HOLD1    = 2'd1,
    OM_CLR_RISE = 2'd2,
    OM_SET_RISE = 2'd3
  } out_mode_e;

  localparam int unsigned NREG = 2;
  localparam int unsigned IDX_PER = 0;
  localparam int unsigned IDX_DUTY = 1;

endpackage

// File: rtl/dspwm_dbuf.sv
module dspwm_dbuf #(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] din,
  input  logic         load,
  output logic [W-1:0] act
);

  logic [W-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_q <= INIT;
      act    <= INIT;
    end else begin
      if (wr)   hold_q <= din;
      if (load) act    <= hold_q;
    end
  end

endmodule

// File: rtl/dspwm_ramp.sv
module dspwm_ramp #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [W-1:0] ceil_val,
  output logic [W-1:0] cnt,
  output logic         up,
  output logic         at_ceil,
  output logic         reach_bot
);

  localparam logic [W-1:0] ONE = W'(1);

  logic [W-1:0] cnt_nx;
  logic         up_nx;

  always_comb begin
    if (up) begin
      if (cnt >= ceil_val) begin
        cnt_nx = (cnt == '0) ? '0 : cnt - ONE;
        up_nx  = 1'b0;
      end else begin
        cnt_nx = cnt + ONE;
        up_nx  = 1'b1;
      end
    end else if (cnt == '0) begin
      cnt_nx = (ceil_val == '0) ? '0 : ONE;
      up_nx  = 1'b1;
    end else begin
      cnt_nx = cnt - ONE;
      up_nx  = 1'b0;
    end
  end

  assign at_ceil   = (cnt == ceil_val);
  assign reach_bot = tick && (cnt_nx == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      up  <= 1'b1;
    end else if (tick) begin
      cnt <= cnt_nx;
      up  <= up_nx;
    end
  end

endmodule

// File: rtl/dspwm_wave.sv
module dspwm_wave
  import dspwm_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [W-1:0] cnt,
  input  logic         up,
  input  logic [W-1:0] ceil_val,
  input  logic [W-1:0] duty,
  input  logic [1:0]   mode,
  output logic         match,
  output logic         pin
);

  logic      fall_lvl;
  out_mode_e om;

  assign om    = out_mode_e'(mode);
  assign match = tick && (cnt == duty);

  always_comb begin
    if (cnt == ceil_val)  fall_lvl = 1'b1;
    else if (cnt == '0)   fall_lvl = 1'b0;
    else                  fall_lvl = !up;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pin <= 1'b0;
    end else if (match) begin
      case (om)
        OM_CLR_RISE: pin <= fall_lvl;
        OM_SET_RISE: pin <= !fall_lvl;
        default:     pin <= pin;
      endcase
    end
  end

endmodule

// File: rtl/dspwm_flag.sv
module dspwm_flag (
  input  logic clk,
  input  logic rst,
  input  logic set,
  input  logic clr,
  output logic q
);

  always_ff @(posedge clk) begin
    if (rst)      q <= 1'b0;
    else if (set) q <= 1'b1;
    else if (clr) q <= 1'b0;
  end

endmodule

// File: rtl/dspwm_timer.sv
module dspwm_timer
  import dspwm_pkg::*;
#(
  parameter int unsigned W = 8,
  parameter logic [W-1:0] PER_INIT  = '1,
  parameter logic [W-1:0] DUTY_INIT = {1'b1, {(W-1){1'b0}}}
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic         top_sel,
  input  logic [1:0]   out_mode,
  input  logic         per_wr,
  input  logic [W-1:0] per_data,
  input  logic         duty_wr,
  input  logic [W-1:0] duty_data,
  input  logic         bot_clr,
  input  logic         cmp_clr,
  output logic         pwm_out,
  output logic [W-1:0] count,
  output logic         count_up,
  output logic         bot_flag,
  output logic         cmp_flag
);

  localparam logic [W-1:0] FULL = '1;
  localparam logic [NREG-1:0][W-1:0] INITS = {DUTY_INIT, PER_INIT};

  logic [NREG-1:0]        wr_v;
  logic [NREG-1:0][W-1:0] din_v;
  logic [NREG-1:0][W-1:0] act_v;
  logic [W-1:0]           ceil_val;
  logic                   at_ceil;
  logic                   reach_bot;
  logic                   match;
  logic                   load;

  assign wr_v[IDX_PER]   = per_wr;
  assign wr_v[IDX_DUTY]  = duty_wr;
  assign din_v[IDX_PER]  = per_data;
  assign din_v[IDX_DUTY] = duty_data;

  assign ceil_val = top_sel ? act_v[IDX_PER] : FULL;
  assign load     = tick && at_ceil;

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    dspwm_dbuf #(.W(W), .INIT(INITS[i])) u_reg (
      .clk (clk),
      .rst (rst),
      .wr  (wr_v[i]),
      .din (din_v[i]),
      .load(load),
      .act (act_v[i])
    );
  end

  dspwm_ramp #(.W(W)) u_ramp (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .ceil_val (ceil_val),
    .cnt      (count),
    .up       (count_up),
    .at_ceil  (at_ceil),
    .reach_bot(reach_bot)
  );

  dspwm_wave #(.W(W)) u_wave (
    .clk     (clk),
    .rst     (rst),
    .tick    (tick),
    .cnt     (count),
    .up      (count_up),
    .ceil_val(ceil_val),
    .duty    (act_v[IDX_DUTY]),
    .mode    (out_mode),
    .match   (match),
    .pin     (pwm_out)
  );

  logic [1:0] fset, fclr, fq;
  assign fset = {match, reach_bot};
  assign fclr = {cmp_clr, bot_clr};

  for (genvar f = 0; f < 2; f++) begin : g_flag
    dspwm_flag u_flag (
      .clk(clk),
      .rst(rst),
      .set(fset[f]),
      .clr(fclr[f]),
      .q  (fq[f])
    );
  end

  assign bot_flag = fq[0];
  assign cmp_flag = fq[1];

endmodule

// File: rtl/dspwm_timer_chk.sv
module dspwm_timer_chk #(
  parameter int unsigned W = 8
) (
  input logic         clk,
  input logic         rst,
  input logic         tick,
  input logic [1:0]   out_mode,
  input logic         bot_clr,
  input logic         cmp_clr,
  input logic         pwm_out,
  input logic [W-1:0] count,
  input logic         count_up,
  input logic         bot_flag,
  input logic         cmp_flag
);

  localparam logic [W-1:0] ONE = W'(1);

  a_r2_freeze_no_tick: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(count) && $stable(count_up)));

  a_r1_unit_step: assert property (@(posedge clk) disable iff (rst)
    tick |=> ((count == $past(count) + ONE) || (count == $past(count) - ONE) ||
              (count == '0 && $past(count) == '0)));

  a_r1_bottom_turn: assert property (@(posedge clk) disable iff (rst)
    (tick && count == '0 && !count_up) |=> count_up);

  a_r6_pin_hold: assert property (@(posedge clk) disable iff (rst)
    !out_mode[1] |=> $stable(pwm_out));

  a_r8_bottom_set: assert property (@(posedge clk) disable iff (rst)
    (tick && count == ONE && !count_up) |=> bot_flag);

  a_r10_bot_sticky: assert property (@(posedge clk) disable iff (rst)
    (bot_flag && !bot_clr) |=> bot_flag);

  a_r10_cmp_sticky: assert property (@(posedge clk) disable iff (rst)
    (cmp_flag && !cmp_clr) |=> cmp_flag);

endmodule

bind dspwm_timer dspwm_timer_chk #(.W(W)) u_chk (
  .clk     (clk),
  .rst     (rst),
  .tick    (tick),
  .out_mode(out_mode),
  .bot_clr (bot_clr),
  .cmp_clr (cmp_clr),
  .pwm_out (pwm_out),
  .count   (count),
  .count_up(count_up),
  .bot_flag(bot_flag),
  .cmp_flag(cmp_flag)
);

// File: tb/dspwm_timer_bench.sv
`timescale 1ns/1ps
module dspwm_timer_bench;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic       top_sel = 1'b0;
  logic [1:0] out_mode = 2'd2;
  logic       per_wr = 1'b0;
  logic [7:0] per_data = '0;
  logic       duty_wr = 1'b0;
  logic [7:0] duty_data = '0;
  logic       bot_clr = 1'b0;
  logic       cmp_clr = 1'b0;
  logic       pwm_out;
  logic [7:0] count;
  logic       count_up;
  logic       bot_flag;
  logic       cmp_flag;

  int n_tests = 0;
  int n_fail  = 0;

  always #2.5 clk = ~clk;

  dspwm_timer u_dspwm_timer (
    .clk(clk), .rst(rst), .tick(tick), .top_sel(top_sel), .out_mode(out_mode),
    .per_wr(per_wr), .per_data(per_data), .duty_wr(duty_wr), .duty_data(duty_data),
    .bot_clr(bot_clr), .cmp_clr(cmp_clr), .pwm_out(pwm_out), .count(count),
    .count_up(count_up), .bot_flag(bot_flag), .cmp_flag(cmp_flag)
  );

  // reference state built from the requirements
  logic [7:0] m_cnt, m_per_h, m_per_a, m_duty_h, m_duty_a;
  logic       m_up, m_pin, m_bf, m_cf;

  function automatic logic [7:0] ceil_of(input logic sel, input logic [7:0] per);
    return sel ? per : 8'hFF;
  endfunction

  task automatic model_step();
    logic [7:0] c, nc;
    logic       nu, lvl, mt, nb, ld;
    if (rst) begin
      m_cnt = 0; m_up = 1; m_pin = 0; m_bf = 0; m_cf = 0;
      m_per_h = 8'hFF; m_per_a = 8'hFF; m_duty_h = 8'h80; m_duty_a = 8'h80;
      return;
    end
    c  = ceil_of(top_sel, m_per_a);
    nc = m_cnt; nu = m_up; mt = 0; nb = 0; ld = 0;
    if (tick) begin
      if (m_up && m_cnt < c) begin nc = m_cnt + 1; nu = 1; end
      else if (m_up) begin nc = (m_cnt == 0) ? 8'd0 : m_cnt - 1; nu = 0; end
      else if (m_cnt == 0) begin nc = (c == 0) ? 8'd0 : 8'd1; nu = 1; end
      else begin nc = m_cnt - 1; nu = 0; end
      mt = (m_cnt == m_duty_a);
      nb = (nc == 0);
      ld = (m_cnt == c);
      lvl = (m_cnt == c) ? 1'b1 : (m_cnt == 0) ? 1'b0 : !m_up;
      if (mt && out_mode == 2'd2) m_pin = lvl;
      if (mt && out_mode == 2'd3) m_pin = !lvl;
    end
    m_bf = nb ? 1'b1 : (bot_clr ? 1'b0 : m_bf);
    m_cf = mt ? 1'b1 : (cmp_clr ? 1'b0 : m_cf);
    if (ld) begin m_per_a = m_per_h; m_duty_a = m_duty_h; end
    if (per_wr)  m_per_h  = per_data;
    if (duty_wr) m_duty_h = duty_data;
    m_cnt = nc; m_up = nu;
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic compare_all();
    string ptag;
    ptag = (out_mode == 2'd2) ? "R4 pin" : (out_mode == 2'd3) ? "R5 pin" : "R6 pin";
    chk("R1 count", count, m_cnt);
    chk("R1 slope", count_up, m_up);
    chk(ptag, pwm_out, m_pin);
    chk("R8 bot_flag", bot_flag, m_bf);
    chk("R9 cmp_flag", cmp_flag, m_cf);
  endtask

  task automatic cyc();
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare_all();
    per_wr = 0; duty_wr = 0; bot_clr = 0; cmp_clr = 0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  initial begin
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    run(2);
    rst = 0;
    chk("R11 count", count, 0);
    chk("R11 slope", count_up, 1);
    chk("R11 pin", pwm_out, 0);
    chk("R11 flags", {bot_flag, cmp_flag}, 0);

    // R2: no tick, no movement
    run(5);
    chk("R2 count held", count, 0);

    // R7: buffered duty write, fixed ceiling 0xFF, mode 2
    tick = 1; out_mode = 2'd2; top_sel = 0;
    while (count != 8'h20) cyc();
    duty_data = 8'h40; duty_wr = 1; cyc();
    while (count != 8'h50) cyc();
    chk("R7 old duty still active", cmp_flag, 0);
    chk("R3 fixed ceiling passes 0x50", count_up, 1);
    while (!(count == 8'h30 && !count_up)) cyc();
    chk("R7 new duty matched on fall", cmp_flag, 1);
    chk("R7 pin set on fall", pwm_out, 1);

    // R12 / R3: register ceiling 6, duty 0
    per_data = 8'd6; per_wr = 1; duty_data = 8'd0; duty_wr = 1; cyc();
    while (!(count == 8'hFF)) cyc();
    cyc();
    top_sel = 1;
    run(300);
    for (int i = 0; i < 24; i++) begin
      cyc();
      chk("R12 duty 0 keeps pin low", pwm_out, 0);
      chk("R3 ceiling 6 bound", (count <= 8'd6), 1);
    end
    // R10 set wins over clear
    while (!(count == 8'd1 && !count_up)) cyc();
    bot_clr = 1; cyc();
    chk("R10 set beats clear", bot_flag, 1);
    bot_clr = 1; cyc();
    chk("R10 clear strobe", bot_flag, 0);
    // duty equal to ceiling
    duty_data = 8'd6; duty_wr = 1; cyc();
    run(30);
    for (int i = 0; i < 24; i++) begin
      cyc();
      chk("R12 duty at ceiling keeps pin high", pwm_out, 1);
    end
    // R6: hold modes
    out_mode = 2'd0; duty_data = 8'd3; duty_wr = 1; cyc();
    run(40);
    chk("R6 pin held in mode 0", pwm_out, 1);
    // R5 inverting
    out_mode = 2'd3; run(40);

    // random phase
    for (int i = 0; i < 6000; i++) begin
      tick = ($urandom % 4) != 0;
      if ($urandom % 20 == 0) begin per_wr = 1; per_data = 8'($urandom % 16); end
      if ($urandom % 20 == 0) begin duty_wr = 1; duty_data = 8'($urandom % 18); end
      if ($urandom % 400 == 0) top_sel = !top_sel;
      if ($urandom % 50 == 0) out_mode = 2'($urandom % 4);
      bot_clr = ($urandom % 8) == 0;
      cmp_clr = ($urandom % 8) == 0;
      rst = (i == 3000);
      cyc();
      if (i == 3000) begin
        rst = 0;
        chk("R11 reset mid-run count", count, 0);
        chk("R11 reset mid-run pin", pwm_out, 0);
      end
    end

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule